// File: doc/BRIEF.md
# Bitmask Microcode Sequencer

This block issues the per-cycle control strobes for two multi-cycle stack instructions: one saves all seven general registers to the stack and one restores them. Each control line has a fixed bit pattern. Bit n of a line's pattern drives that line high on tick n of the instruction. Tick 0 is the clock cycle that follows the rising edge at which the start request was taken. A few lines are deliberately skewed. The stack-pointer step lines come out one tick later than their pattern says. The memory-cell clear comes out one tick earlier.

A one-tick `start_i` pulse with a program code on `prog_i` launches a sequence. `busy_o` stays high until the last strobe of that sequence has been issued. While `busy_o` is high, further start requests are ignored. The register file, the stack memory and the program counter sit outside the block and simply obey the strobes. Seven register slots are numbered 0 to 6. The save program reads them in ascending slot order and the restore program writes them in descending order.

Top module: `ucode_strobe_seq`

## Requirements
- R1: During reset and after its release, with no start request, every strobe output and `busy_o` are low.
- R2: Save program (`prog_i` = 1): `mem_wr_o` is high on ticks 1 through 14 and low on every other tick (pattern 0x7FFE).
- R3: Save program: `sp_dec_o` is high on ticks 1, 3, 5, 7, 9, 11 and 13 only. Its pattern 0x1555 is issued one tick late.
- R4: Save program: `cell_clr_o` is high on ticks 1, 3, 5, 7, 9, 11 and 13 only. Its pattern 0x5554 is issued one tick early.
- R5: Save program: `rd_sel_o` (bit k selects slot k) is one-hot on even ticks: slot 0 on tick 2, slot 1 on tick 4, and so on up to slot 6 on tick 14. It is zero on every other tick.
- R6: `fetch_o` and `pc_inc_o` are both high on exactly one tick: tick 9 of the save program (pattern 0x200) and tick 8 of the restore program (pattern 0x100).
- R7: Restore program (`prog_i` = 2): `mem_rd_o` is high on ticks 0 through 6. `sp_inc_o` is high on ticks 1 through 7 (pattern 0x7F, issued one tick late). `wr_sel_o` selects slot 6 on tick 1, slot 5 on tick 2, and so on down to slot 0 on tick 7. The whole sequence spans 9 ticks.
- R8: `busy_o` is high from tick 0 through the last strobe tick (tick 14 for save, tick 8 for restore) and low afterwards. A start request presented on the first cycle with `busy_o` low is accepted, and its tick 0 is the next cycle.
- R9: A start request taken while `busy_o` is high is ignored. The running sequence continues unchanged and nothing else is queued.
- R10: Program codes 0 and 3 have empty patterns: a start request with either code raises no strobe and leaves `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken at a rising edge when not busy |
| prog_i | input | 2 | Program code: 1 save all, 2 restore all, 0 and 3 empty |
| busy_o | output | 1 | A sequence still has strobes to issue |
| sp_dec_o | output | 1 | Decrement the stack pointer |
| sp_inc_o | output | 1 | Increment the stack pointer |
| mem_wr_o | output | 1 | Write the selected register to the stack top |
| mem_rd_o | output | 1 | Read the stack top |
| cell_clr_o | output | 1 | Clear the addressed memory cell ahead of a write |
| fetch_o | output | 1 | Fetch the next instruction |
| pc_inc_o | output | 1 | Advance the program counter |
| rd_sel_o | output | 7 | One-hot register read select, bit k is slot k |
| wr_sel_o | output | 7 | One-hot register write select, bit k is slot k |

## Verification
Every strobe and `busy_o` come straight from registers. A start request driven before rising edge E therefore shows its tick-0 values in the cycle after E, and tick n shows n cycles after that. The bench drives and samples on falling edges. It counts one falling edge past the accepting rising edge as tick 0 and one more per tick. It compares every output on every tick of a 20-tick window against a tick-indexed formula for each program code. In the back-to-back runs, a held start request has to stay ignored through the last busy tick and be taken on the first idle one. For that case the expected trace switches to the second program 16 ticks after the first was launched.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        PROG_EMPTY0   = 2'd0,
        PROG_SAVE_ALL = 2'd1,
        PROG_LOAD_ALL = 2'd2,
        PROG_EMPTY3   = 2'd3
    } prog_e;

    localparam int NUM_SLOTS   = 7;
    localparam int PATTERN_W   = 32;

    // control line indices
    localparam int LN_SP_DEC   = 0;
    localparam int LN_SP_INC   = 1;
    localparam int LN_MEM_WR   = 2;
    localparam int LN_MEM_RD   = 3;
    localparam int LN_CELL_CLR = 4;
    localparam int LN_FETCH    = 5;
    localparam int LN_PC_INC   = 6;
    localparam int LN_RD_BASE  = 7;
    localparam int LN_WR_BASE  = LN_RD_BASE + NUM_SLOTS;
    localparam int NUM_LINES   = LN_WR_BASE + NUM_SLOTS;

    // +1: issued one tick late, -1: one tick early, 0: on time
    function automatic int line_skew(input int ln);
        if (ln == LN_SP_DEC || ln == LN_SP_INC) return 1;
        if (ln == LN_CELL_CLR) return -1;
        return 0;
    endfunction

    function automatic logic [PATTERN_W-1:0] line_pattern(input prog_e p, input int ln);
        logic [PATTERN_W-1:0] m;
        m = '0;
        case (p)
            PROG_SAVE_ALL: begin
                if (ln == LN_SP_DEC)   m = 32'h0000_1555;
                if (ln == LN_MEM_WR)   m = 32'h0000_7FFE;
                if (ln == LN_CELL_CLR) m = 32'h0000_5554;
                if (ln == LN_FETCH)    m = 32'h0000_0200;
                if (ln == LN_PC_INC)   m = 32'h0000_0200;
                if (ln >= LN_RD_BASE && ln < LN_RD_BASE + NUM_SLOTS)
                    m = 32'd1 << (2 * (ln - LN_RD_BASE) + 2);
            end
            PROG_LOAD_ALL: begin
                if (ln == LN_MEM_RD)   m = 32'h0000_007F;
                if (ln == LN_SP_INC)   m = 32'h0000_007F;
                if (ln == LN_FETCH)    m = 32'h0000_0100;
                if (ln == LN_PC_INC)   m = 32'h0000_0100;
                if (ln >= LN_WR_BASE && ln < LN_WR_BASE + NUM_SLOTS)
                    m = 32'd1 << (NUM_SLOTS - (ln - LN_WR_BASE));
            end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/useq_pattern_rom.sv
module useq_pattern_rom
    import useq_pkg::*;
#(
    parameter int MASK_W = 32
) (
    input  logic [1:0]                            prog_i,
    output logic [NUM_LINES-1:0][MASK_W-1:0]      masks_o
);

    prog_e prog_sel;
    assign prog_sel = prog_e'(prog_i);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign masks_o[g] = MASK_W'(line_pattern(prog_sel, g));
    end

endmodule

// File: rtl/useq_lane.sv
module useq_lane #(
    parameter int MASK_W = 32,
    parameter int SKEW   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic              strobe_o,
    output logic              pending_o
);

    // an early lane has already issued bit 0 of its shifted pattern
    localparam logic [MASK_W-1:0] PEND_MASK =
        (SKEW < 0) ? {{(MASK_W-1){1'b1}}, 1'b0} : {MASK_W{1'b1}};

    typedef struct packed {
        logic [MASK_W-1:0] sh;
        logic              dl;
    } lane_s;

    lane_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) st_d.sh = mask_i;
        else        st_d.sh = st_q.sh >> 1;
        st_d.dl = (SKEW > 0) ? st_q.sh[0] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    if (SKEW > 0) begin : g_late
        assign strobe_o = st_q.dl;
    end else if (SKEW < 0) begin : g_early
        assign strobe_o = st_q.sh[1];
    end else begin : g_ontime
        assign strobe_o = st_q.sh[0];
    end

    assign pending_o = (|(st_q.sh & PEND_MASK)) | st_q.dl;

endmodule

// File: rtl/ucode_strobe_seq.sv
module ucode_strobe_seq
    import useq_pkg::*;
#(
    parameter int MASK_W = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] prog_i,
    output logic       busy_o,
    output logic       sp_dec_o,
    output logic       sp_inc_o,
    output logic       mem_wr_o,
    output logic       mem_rd_o,
    output logic       cell_clr_o,
    output logic       fetch_o,
    output logic       pc_inc_o,
    output logic [6:0] rd_sel_o,
    output logic [6:0] wr_sel_o
);

    logic [NUM_LINES-1:0][MASK_W-1:0] masks;
    logic [NUM_LINES-1:0]             strobes;
    logic [NUM_LINES-1:0]             pend;
    logic                             load;

    useq_pattern_rom #(.MASK_W(MASK_W)) i_rom (
        .prog_i  (prog_i),
        .masks_o (masks)
    );

    assign load = start_i & ~busy_o;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
        useq_lane #(.MASK_W(MASK_W), .SKEW(line_skew(g))) i_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load),
            .mask_i    (masks[g]),
            .strobe_o  (strobes[g]),
            .pending_o (pend[g])
        );
    end

    assign busy_o     = |pend;
    assign sp_dec_o   = strobes[LN_SP_DEC];
    assign sp_inc_o   = strobes[LN_SP_INC];
    assign mem_wr_o   = strobes[LN_MEM_WR];
    assign mem_rd_o   = strobes[LN_MEM_RD];
    assign cell_clr_o = strobes[LN_CELL_CLR];
    assign fetch_o    = strobes[LN_FETCH];
    assign pc_inc_o   = strobes[LN_PC_INC];
    assign rd_sel_o   = strobes[LN_RD_BASE +: NUM_SLOTS];
    assign wr_sel_o   = strobes[LN_WR_BASE +: NUM_SLOTS];

endmodule

// File: rtl/ucode_strobe_seq_chk.sv
module ucode_strobe_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [1:0] prog_i,
    input logic       busy_o,
    input logic       sp_dec_o,
    input logic       sp_inc_o,
    input logic       mem_wr_o,
    input logic       mem_rd_o,
    input logic       cell_clr_o,
    input logic       fetch_o,
    input logic       pc_inc_o,
    input logic [6:0] rd_sel_o,
    input logic [6:0] wr_sel_o
);

    AST_RDSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_sel_o)); // R5

    AST_WRSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel_o)); // R7

    AST_FETCH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o == pc_inc_o); // R6

    AST_CLR_WITH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        cell_clr_o == sp_dec_o); // R4

    AST_WR_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        cell_clr_o |=> mem_wr_o); // R4

    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> ($countones(wr_sel_o) == 1)); // R7

    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_dec_o || sp_inc_o || mem_wr_o || mem_rd_o || cell_clr_o || fetch_o
         || (|rd_sel_o) || (|wr_sel_o)) |-> busy_o); // R8

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (prog_i == 2'd1 || prog_i == 2'd2)) |=> busy_o); // R8

    AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (prog_i == 2'd0 || prog_i == 2'd3)) |=> !busy_o); // R10

endmodule

bind ucode_strobe_seq ucode_strobe_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .prog_i     (prog_i),
    .busy_o     (busy_o),
    .sp_dec_o   (sp_dec_o),
    .sp_inc_o   (sp_inc_o),
    .mem_wr_o   (mem_wr_o),
    .mem_rd_o   (mem_rd_o),
    .cell_clr_o (cell_clr_o),
    .fetch_o    (fetch_o),
    .pc_inc_o   (pc_inc_o),
    .rd_sel_o   (rd_sel_o),
    .wr_sel_o   (wr_sel_o)
);

// File: tb/test_ucode_strobe_seq.sv
`timescale 1ns/1ps
module test_ucode_strobe_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [1:0] prog_i;
    logic       busy_o, sp_dec_o, sp_inc_o, mem_wr_o, mem_rd_o;
    logic       cell_clr_o, fetch_o, pc_inc_o;
    logic [6:0] rd_sel_o, wr_sel_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ucode_strobe_seq i_ucode_strobe_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .prog_i(prog_i),
        .busy_o(busy_o), .sp_dec_o(sp_dec_o), .sp_inc_o(sp_inc_o),
        .mem_wr_o(mem_wr_o), .mem_rd_o(mem_rd_o), .cell_clr_o(cell_clr_o),
        .fetch_o(fetch_o), .pc_inc_o(pc_inc_o),
        .rd_sel_o(rd_sel_o), .wr_sel_o(wr_sel_o)
    );

    task automatic cmp(input logic [6:0] act, input logic [6:0] exp,
                       input string tag, input string scen, input int t);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s%s tick %0d: actual %0h expected %0h", scen, tag, t, act, exp);
        end
    endtask

    // expected outputs computed from the requirement formulas
    task automatic check_tick(input int p, input int t, input string scen);
        logic e_busy, e_dec, e_inc, e_wr, e_rd, e_clr, e_fetch;
        logic [6:0] e_rsel, e_wsel;
        string s;
        e_busy = 0; e_dec = 0; e_inc = 0; e_wr = 0; e_rd = 0; e_clr = 0; e_fetch = 0;
        e_rsel = '0; e_wsel = '0;
        s = scen;
        if (p == 1) begin
            e_busy  = (t >= 0 && t <= 14);
            e_wr    = (t >= 1 && t <= 14);
            e_dec   = (t >= 1 && t <= 13 && (t % 2) == 1);
            e_clr   = e_dec;
            e_fetch = (t == 9);
            if (t >= 2 && t <= 14 && (t % 2) == 0) e_rsel = 7'd1 << ((t - 2) / 2);
        end else if (p == 2) begin
            e_busy  = (t >= 0 && t <= 8);
            e_rd    = (t >= 0 && t <= 6);
            e_inc   = (t >= 1 && t <= 7);
            e_fetch = (t == 8);
            if (t >= 1 && t <= 7) e_wsel = 7'd1 << (7 - t);
        end else begin
            s = {scen, "R10 "};
        end
        cmp({6'd0, busy_o},     {6'd0, e_busy},  "R8 busy",     s, t);
        cmp({6'd0, mem_wr_o},   {6'd0, e_wr},    "R2 mem_wr",   s, t);
        cmp({6'd0, sp_dec_o},   {6'd0, e_dec},   "R3 sp_dec",   s, t);
        cmp({6'd0, cell_clr_o}, {6'd0, e_clr},   "R4 cell_clr", s, t);
        cmp(rd_sel_o,           e_rsel,          "R5 rd_sel",   s, t);
        cmp({6'd0, fetch_o},    {6'd0, e_fetch}, "R6 fetch",    s, t);
        cmp({6'd0, pc_inc_o},   {6'd0, e_fetch}, "R6 pc_inc",   s, t);
        cmp({6'd0, mem_rd_o},   {6'd0, e_rd},    "R7 mem_rd",   s, t);
        cmp({6'd0, sp_inc_o},   {6'd0, e_inc},   "R7 sp_inc",   s, t);
        cmp(wr_sel_o,           e_wsel,          "R7 wr_sel",   s, t);
    endtask

    // at a falling edge: raise start; returns at the falling edge of tick 0
    task automatic launch(input int p);
        start_i = 1'b1;
        prog_i  = 2'(p);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; prog_i = 2'd0;
        repeat (3) @(negedge clk);
        check_tick(0, 0, "R1 ");   // in reset
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_tick(0, 0, "R1 ");   // after release

        // every program code, full window
        for (int p = 0; p < 4; p++) begin
            launch(p);
            start_i = 1'b0;
            for (int t = 0; t < 20; t++) begin
                check_tick(p, t, "");
                @(negedge clk);
            end
        end

        // R9: restart request held during save, taken on first idle cycle (R8)
        launch(1);
        prog_i = 2'd2;
        for (int t = 0; t < 28; t++) begin
            if (t <= 15) check_tick(1, t, "R9 ");
            else         check_tick(2, t - 16, "R8 ");
            if (t == 16) start_i = 1'b0;
            @(negedge clk);
        end

        // R9: save request held during restore, dropped before it ends
        launch(2);
        prog_i = 2'd1;
        for (int t = 0; t < 16; t++) begin
            check_tick(2, t, "R9 ");
            if (t == 8) start_i = 1'b0;
            @(negedge clk);
        end

        // R10 with start held several cycles on an empty code
        launch(3);
        for (int t = 0; t < 6; t++) begin
            check_tick(3, t, "");
            @(negedge clk);
        end
        start_i = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule